// File: doc/BRIEF.md
# Display List Instruction Executor

A small command processor that consumes a stream of byte-coded display-list instructions, one instruction at a time, and turns them into register writes and control events. An instruction is one or two bytes long. Two-byte instructions write an 8-bit value to a numbered register. The value is either an immediate byte or a byte read through one of two memory ports. The register number decides where the write lands:
- Low numbers go to an external video-chip register bus, which may be busy and can stall the executor.
- Higher numbers go to an on-chip write port, which always completes in one cycle.

One-byte instructions cover four cases:
- a no-op;
- a request to raise a host interrupt, which takes effect only when a mask bit is set;
- arming a one-shot skip flag, which a separate beam-wait unit consumes on its next WAIT;
- undefined opcodes, which behave as no-ops and set a sticky error flag.

Top module: `dl_exec`

## Requirements
- R1: A first byte of the form 11RRRRRR starts a two-byte move. The following byte is written to register R (6 bits). For R in 0x00..0x2E, it appears as an external write (`ext_we`, `ext_addr`=R, `ext_data`=value) from the cycle after the value byte is taken.
- R2: A first byte of the form 100RRRRR is a two-byte internal move. The value goes to on-chip address 0x40+R, issued as a single-cycle `loc_we` pulse in the cycle after the value byte is taken, with no stall and no gap before the next opcode.
- R3: Target addresses 0x00..0x2E always use the external bus. Addresses 0x2F and above always use the on-chip port (`loc_addr` is 7 bits wide).
- R4: While an external write is pending and `ext_busy` is high, `ext_we`, `ext_addr` and `ext_data` hold steady and `ins_ready` is low. The write completes on the first clock edge with `ext_busy` low, and fetching then resumes.
- R5: Opcode 0xA5 is a two-byte transfer. In its second byte, bit 7 selects port P and bits 6:0 give target register R. The byte on `portP_data` is written to R under the R3/R4 rules. `port_rd[P]` is high for exactly the cycle in which that second byte is taken.
- R6: Opcode 0xA7 is a one-byte no-op. It makes no write, and the next byte is accepted in the following cycle.
- R7: Opcode 0xA6 sets `skip_armed`. A `wait_done` pulse clears it. Arming again while it is set leaves it set. If arming and `wait_done` happen in the same cycle, the flag ends up set.
- R8: Opcode 0xA2 raises the interrupt only when `irq_en` is 1. Raising drives `irq_n` low and sets bits 4 and 7 of `irq_flags` (value 0x90). When `irq_en` is 0, the opcode has no effect.
- R9: A raised interrupt keeps `irq_n` low until `host_ack` is pulsed. The ack returns `irq_n` high and clears `irq_flags` to 0x00.
- R10: Any byte that is not a valid opcode is consumed as a one-byte no-op and sets `err`, which stays set until reset. The valid opcodes are 11xxxxxx, 100xxxxx, 0xA2, 0xA5, 0xA6 and 0xA7. After an undefined byte, the next byte is decoded as an opcode.
- R11: After reset, `ins_ready`=1, `ext_we`=0, `loc_we`=0, `port_rd`=0, `irq_n`=1, `irq_flags`=0, `skip_armed`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ins_valid | input | 1 | Instruction byte present |
| ins_byte | input | 8 | Instruction byte |
| ins_ready | output | 1 | Executor takes the byte this cycle |
| ext_we | output | 1 | External register write request |
| ext_addr | output | 6 | External register number |
| ext_data | output | 8 | External write value |
| ext_busy | input | 1 | External bus occupied; write must wait |
| loc_we | output | 1 | On-chip register write strobe |
| loc_addr | output | 7 | On-chip register number |
| loc_data | output | 8 | On-chip write value |
| port_rd | output | 2 | Read strobe per memory port (advances its address) |
| port0_data | input | 8 | Byte at port 0's current address |
| port1_data | input | 8 | Byte at port 1's current address |
| irq_en | input | 1 | Interrupt mask bit |
| host_ack | input | 1 | Host acknowledge of the raised interrupt |
| irq_n | output | 1 | Active-low host interrupt |
| irq_flags | output | 8 | Interrupt status; bits 4 and 7 used |
| wait_done | input | 1 | Wait unit consumed the skip flag |
| skip_armed | output | 1 | Skip modifier for the next WAIT |
| err | output | 1 | Sticky undefined-opcode flag |

## Verification
The executor is driven with the following instruction patterns:
- Immediate moves to both sides of the 0x2E/0x2F boundary and to the internal range. These distinguish external from on-chip routing and check the 0x40 offset.
- A move issued while the external bus is busy. This separates a correct stall, with the write held and fetching blocked, from a write that slips through or a fetch that runs ahead.
- Transfers from each port. These check the port-select bit and per-port read strobes against swapped or merged ports.
- No-ops, undefined bytes, skip arming with and without a concurrent `wait_done`, and interrupt requests with the mask both cleared and set. These are each followed by a move, which shows that one-byte opcodes consume exactly one byte and produce no stray write.

// File: rtl/dl_exec.sv
module dl_exec #(
  parameter logic [6:0] EXT_TOP = 7'h2E,
  parameter logic [7:0] OP_IRQ  = 8'hA2,
  parameter logic [7:0] OP_XFER = 8'hA5,
  parameter logic [7:0] OP_SKIP = 8'hA6,
  parameter logic [7:0] OP_NOP  = 8'hA7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ins_valid,
  input  logic [7:0] ins_byte,
  output logic       ins_ready,
  output logic       ext_we,
  output logic [5:0] ext_addr,
  output logic [7:0] ext_data,
  input  logic       ext_busy,
  output logic       loc_we,
  output logic [6:0] loc_addr,
  output logic [7:0] loc_data,
  output logic [1:0] port_rd,
  input  logic [7:0] port0_data,
  input  logic [7:0] port1_data,
  input  logic       irq_en,
  input  logic       host_ack,
  output logic       irq_n,
  output logic [7:0] irq_flags,
  input  logic       wait_done,
  output logic       skip_armed,
  output logic       err
);

  typedef enum logic [1:0] {S_OP, S_ARG, S_EXT} st_t;
  typedef enum logic [1:0] {K_MOV, K_MOVI, K_XFER} kind_t;

  st_t        st;
  kind_t      kind;
  logic [6:0] tgt;
  logic       irq_q;

  logic       take, in_op, in_arg, is_xfer;
  logic [6:0] wa;
  logic [7:0] wd;
  logic       to_ext;

  assign ins_ready = (st != S_EXT);
  assign take      = ins_valid && ins_ready;
  assign in_op     = take && (st == S_OP);
  assign in_arg    = take && (st == S_ARG);
  assign is_xfer   = (kind == K_XFER);
  assign wa        = is_xfer ? ins_byte[6:0] : tgt;
  assign wd        = !is_xfer ? ins_byte : (ins_byte[7] ? port1_data : port0_data);
  assign to_ext    = (wa <= EXT_TOP);
  assign port_rd   = {in_arg && is_xfer && ins_byte[7], in_arg && is_xfer && !ins_byte[7]};

  assign irq_n     = !irq_q;
  assign irq_flags = {irq_q, 2'b00, irq_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_OP;
      kind       <= K_MOV;
      tgt        <= '0;
      ext_we     <= 1'b0;
      ext_addr   <= '0;
      ext_data   <= '0;
      loc_we     <= 1'b0;
      loc_addr   <= '0;
      loc_data   <= '0;
      skip_armed <= 1'b0;
      err        <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      loc_we <= 1'b0;
      if (wait_done) skip_armed <= 1'b0;
      if (host_ack)  irq_q <= 1'b0;
      case (st)
        S_OP: if (in_op) begin
          if (ins_byte[7:6] == 2'b11) begin
            kind <= K_MOV;
            tgt  <= {1'b0, ins_byte[5:0]};
            st   <= S_ARG;
          end else if (ins_byte[7:5] == 3'b100) begin
            kind <= K_MOVI;
            tgt  <= 7'h40 | {2'b00, ins_byte[4:0]};
            st   <= S_ARG;
          end else if (ins_byte == OP_XFER) begin
            kind <= K_XFER;
            st   <= S_ARG;
          end else if (ins_byte == OP_SKIP) begin
            skip_armed <= 1'b1;
          end else if (ins_byte == OP_IRQ) begin
            if (irq_en) irq_q <= 1'b1;
          end else if (ins_byte != OP_NOP) begin
            err <= 1'b1;
          end
        end
        S_ARG: if (in_arg) begin
          if (to_ext) begin
            ext_we   <= 1'b1;
            ext_addr <= wa[5:0];
            ext_data <= wd;
            st       <= S_EXT;
          end else begin
            loc_we   <= 1'b1;
            loc_addr <= wa;
            loc_data <= wd;
            st       <= S_OP;
          end
        end
        default: if (!ext_busy) begin
          ext_we <= 1'b0;
          st     <= S_OP;
        end
      endcase
    end
  end

  p_ext_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_we && ext_busy) |=> (ext_we && $stable(ext_addr) && $stable(ext_data)));

  p_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> !ins_ready);

  p_ext_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ext_we |-> ({1'b0, ext_addr} <= EXT_TOP));

  p_loc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |-> (loc_addr > EXT_TOP));

  p_loc_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we |=> !loc_we);

  p_port_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(port_rd));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(irq_en));

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !host_ack) |=> !irq_n);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/dl_exec_tb.sv
module dl_exec_tb;

  typedef struct packed {
    logic       is_ext;
    logic [6:0] addr;
    logic [7:0] data;
  } wr_t;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       ins_valid = 0;
  logic [7:0] ins_byte = 0;
  logic       ins_ready;
  logic       ext_we;
  logic [5:0] ext_addr;
  logic [7:0] ext_data;
  logic       ext_busy = 0;
  logic       loc_we;
  logic [6:0] loc_addr;
  logic [7:0] loc_data;
  logic [1:0] port_rd;
  logic [7:0] port0_data = 8'h5A;
  logic [7:0] port1_data = 8'hC3;
  logic       irq_en = 0;
  logic       host_ack = 0;
  logic       irq_n;
  logic [7:0] irq_flags;
  logic       wait_done = 0;
  logic       skip_armed;
  logic       err;

  int checks = 0;
  int errors = 0;
  int rd0 = 0;
  int rd1 = 0;
  wr_t exp_q[$];

  always #2.5 clk = ~clk;

  dl_exec u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_byte(ins_byte),
    .ins_ready(ins_ready), .ext_we(ext_we), .ext_addr(ext_addr), .ext_data(ext_data),
    .ext_busy(ext_busy), .loc_we(loc_we), .loc_addr(loc_addr), .loc_data(loc_data),
    .port_rd(port_rd), .port0_data(port0_data), .port1_data(port1_data),
    .irq_en(irq_en), .host_ack(host_ack), .irq_n(irq_n), .irq_flags(irq_flags),
    .wait_done(wait_done), .skip_armed(skip_armed), .err(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic send(logic [7:0] b);
    ins_valid = 1;
    ins_byte  = b;
    @(negedge clk);
    while (!ins_ready) @(negedge clk);
    @(posedge clk);
    #1;
    ins_valid = 0;
  endtask

  task automatic expect_wr(logic e, logic [6:0] a, logic [7:0] d);
    wr_t w;
    w.is_ext = e; w.addr = a; w.data = d;
    exp_q.push_back(w);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (port_rd[0]) rd0++;
      if (port_rd[1]) rd1++;
      if ((ext_we && !ext_busy) || loc_we) begin
        wr_t got;
        got.is_ext = ext_we && !ext_busy;
        got.addr   = got.is_ext ? {1'b0, ext_addr} : loc_addr;
        got.data   = got.is_ext ? ext_data : loc_data;
        if (exp_q.size() == 0) begin
          chk("R1/R2/R6 unexpected write", {15'd0, got}, 32'hFFFF_FFFF);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk("R1/R2/R3/R5 write", {15'd0, got}, {15'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk("R11 ready", ins_ready, 1);
    chk("R11 writes", {ext_we, loc_we, port_rd}, 0);
    chk("R11 irq", {irq_n, irq_flags}, {1'b1, 8'h00});
    chk("R11 flags", {skip_armed, err}, 0);
    rst_n = 1;
    idle(2);

    // R1 external move, R3 boundary both sides
    expect_wr(1, 7'h12, 8'hA1); send(8'hD2); send(8'hA1);
    expect_wr(1, 7'h2E, 8'h3B); send(8'hEE); send(8'h3B);
    expect_wr(0, 7'h2F, 8'h44); send(8'hEF); send(8'h44);
    expect_wr(0, 7'h31, 8'h07); send(8'hF1); send(8'h07);
    // R2 internal move, back to back
    expect_wr(0, 7'h40, 8'h11); send(8'h80); send(8'h11);
    expect_wr(0, 7'h5F, 8'h22); send(8'h9F); send(8'h22);
    idle(2);

    // R4 stall
    ext_busy = 1;
    expect_wr(1, 7'h05, 8'h99); send(8'hC5); send(8'h99);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 held we/addr/data", {ext_we, ext_addr, ext_data}, {1'b1, 6'h05, 8'h99});
      chk("R4 no fetch", ins_ready, 0);
    end
    @(posedge clk); #1;
    ext_busy = 0;
    @(negedge clk);
    chk("R4 ext_we before release", ext_we, 1);
    @(negedge clk);
    chk("R4 released", {ext_we, ins_ready}, 2'b01);
    idle(1);

    // R5 transfers
    expect_wr(1, 7'h20, 8'h5A); send(8'hA5); send(8'h20);
    expect_wr(0, 7'h45, 8'hC3); send(8'hA5); send(8'hC5);
    expect_wr(0, 7'h33, 8'hC3); send(8'hA5); send(8'hB3);
    idle(2);
    chk("R5 port0 reads", rd0, 1);
    chk("R5 port1 reads", rd1, 2);

    // R6 no-op
    send(8'hA7);
    @(negedge clk);
    chk("R6 ready after nop", ins_ready, 1);
    @(posedge clk); #1;
    expect_wr(0, 7'h42, 8'h66); send(8'h82); send(8'h66);
    idle(2);

    // R7 skip
    send(8'hA6);
    @(negedge clk);
    chk("R7 armed", skip_armed, 1);
    @(posedge clk); #1;
    send(8'hA6);
    @(negedge clk);
    chk("R7 re-arm stays set", skip_armed, 1);
    @(posedge clk); #1;
    wait_done = 1; idle(1); wait_done = 0;
    @(negedge clk);
    chk("R7 cleared by wait", skip_armed, 0);
    @(posedge clk); #1;
    wait_done = 1; send(8'hA6); wait_done = 0;
    @(negedge clk);
    chk("R7 arm wins over wait", skip_armed, 1);
    @(posedge clk); #1;
    wait_done = 1; idle(1); wait_done = 0;

    // R8 masked and unmasked
    irq_en = 0; send(8'hA2);
    idle(1); @(negedge clk);
    chk("R8 masked no effect", {irq_n, irq_flags}, {1'b1, 8'h00});
    @(posedge clk); #1;
    irq_en = 1; send(8'hA2);
    @(negedge clk);
    chk("R8 raised", {irq_n, irq_flags}, {1'b0, 8'h90});
    idle(4); @(negedge clk);
    chk("R9 held until ack", irq_n, 0);
    @(posedge clk); #1;
    host_ack = 1; idle(1); host_ack = 0;
    @(negedge clk);
    chk("R9 acked", {irq_n, irq_flags}, {1'b1, 8'h00});
    @(posedge clk); #1;

    // R10 undefined opcodes
    chk("R10 err clear before", err, 0);
    expect_wr(0, 7'h41, 8'h77); send(8'h13); send(8'h81); send(8'h77);
    @(negedge clk);
    chk("R10 err set", err, 1);
    @(posedge clk); #1;
    expect_wr(1, 7'h01, 8'h55); send(8'hA0); send(8'hC1); send(8'h55);
    idle(3); @(negedge clk);
    chk("R10 err sticky", err, 1);

    idle(3);
    chk("R1/R2 all writes seen", exp_q.size(), 0);
    chk("R5 final port counts", {rd0[15:0], rd1[15:0]}, {16'd1, 16'd2});
    summary();
  end

endmodule